// File: doc/BRIEF.md
# Seconds and Minutes BCD Timekeeper with Counter Freeze

This block keeps time-of-day seconds and minutes as packed BCD digits. A free-running binary divider, clocked by the 32.768 kHz timekeeping clock, produces one tick per second. Each tick advances the units-of-seconds digit, and carries ripple through the tens-of-seconds digit and the two minute digits. After every tick a busy window stands for a fixed number of clock cycles, about 4 ms by default. During that window software must not touch the counters.

Software works through a small register port with one write path and one combinational read path. Address 0 is the control word: bit 0 is the freeze request and reads back its state, and bit 1 is the read-only busy indicator. To load a new time, software asks for a freeze while busy is low and writes the seconds and minutes words. It then drops the freeze. If a tick arrived while the counters were frozen, the counters gain exactly one second at the moment the freeze is dropped. The divider runs on throughout, so the phase of the second ticks does not shift.

A software reset input clears the freeze state and restarts the divider. It leaves the time value alone.

Top module: `rtc_bcd_sec_min`

## Requirements
- R1: Seconds are read and written at address 1 and minutes at address 2. In each word, bits 3:0 hold the units digit and bits 6:4 hold the tens digit. Bit 7 always reads 0, and an unused address reads 0.
- R2: On each one-second tick, the units-of-seconds digit advances by one when below 9. It wraps from 9 to 0 and passes a carry to the tens digit.
- R3: The tens-of-seconds digit runs 0 to 5 and passes a carry into the minute units digit. The minute digits follow the same 0–9 and 0–5 ranges, so 59:59 rolls to 00:00.
- R4: A tick occurs once every 2**DIV_W clock cycles. Busy (control bit 1) is high for BUSY_CYC cycles, starting in the cycle after the clock edge that applied the tick.
- R5: A write of 1 to control bit 0 while busy is high is ignored, and the freeze bit reads back 0.
- R6: While frozen, the time value does not change, busy reads 0, and the divider keeps its phase: ticks after the release stay on the original 2**DIV_W grid.
- R7: Releasing the freeze adds exactly one second if one or more ticks fell inside the freeze, and nothing otherwise.
- R8: Writes to the seconds or minutes words take effect only while frozen. At any other time they are ignored.
- R9: Digit values outside the BCD range are stored as written. At the next increment such a digit wraps to 0 and passes a carry.
- R10: A software reset clears the freeze bit and any pending missed tick, and restarts the divider so the next tick falls 2**DIV_W cycles later. It leaves seconds and minutes unchanged.
- R11: After the hardware reset, seconds, minutes and the control word all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timekeeping clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_rst | input | 1 | Synchronous software reset (time value kept) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 seconds, 2 minutes |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Combinational read data |

## Verification
The counting path is driven from loaded start times: 58, 09 and 59:59 probe the units wrap, the tens wrap into minutes, and the full roll to zero. Codes such as 0x3C, 0x79 and 0xFF separate "stored as written, wrapped on increment" from any clamping. Freeze sequences are tried with no tick inside, with two ticks inside, during the busy window, and with a software reset. These cases separate single-second compensation from none or from a full catch-up, and a refused request from an accepted one. Tick spacing, measured both before and after a freeze and after a software reset, shows whether the divider kept running or was restarted.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      RA_CTRL = 2'd0,
      RA_SEC  = 2'd1,
      RA_MIN  = 2'd2,
      RA_NONE = 2'd3
   } rtc_addr_e;

   localparam int CTRL_FREEZE_BIT = 0;
   localparam int CTRL_BUSY_BIT   = 1;

endpackage

// File: rtl/rtc_subsec_div.sv
module rtc_subsec_div #(
   parameter int DIV_W    = 15,
   parameter int BUSY_CYC = 131
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_rst_i,
   output logic tick_o,
   output logic busy_raw_o
);

   localparam logic [DIV_W-1:0] DIV_LAST = '1;

   if (DIV_W < 2) begin : g_chk_w
      $error("rtc_subsec_div: DIV_W must be at least 2");
   end
   if (BUSY_CYC < 0 || BUSY_CYC >= (1 << DIV_W)) begin : g_chk_busy
      $error("rtc_subsec_div: BUSY_CYC must fit inside one tick period");
   end

   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        div_q <= '0;
      else if (sw_rst_i) div_q <= '0;
      else               div_q <= div_q + 1'b1;
   end

   assign tick_o = (div_q == DIV_LAST);

   if (BUSY_CYC == 0) begin : g_no_busy
      assign busy_raw_o = 1'b0;
   end else begin : g_busy
      localparam int BC_W = $clog2(BUSY_CYC + 1);
      logic [BC_W-1:0] bcnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               bcnt_q <= '0;
         else if (sw_rst_i)        bcnt_q <= '0;
         else if (tick_o)          bcnt_q <= BC_W'(BUSY_CYC);
         else if (bcnt_q != '0)    bcnt_q <= bcnt_q - 1'b1;
      end

      assign busy_raw_o = (bcnt_q != '0);

      // R4
      busy_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick_o && !sw_rst_i |=> busy_raw_o);

      // R4
      busy_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(busy_raw_o) |-> $past(tick_o));
   end

endmodule

// File: rtl/rtc_bcd_digit.sv
module rtc_bcd_digit #(
   parameter int W   = 4,
   parameter int MAX = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   output logic [W-1:0] q_o,
   output logic         carry_o
);

   localparam logic [W-1:0] TOP = W'(MAX);

   if (W < 1 || MAX < 1 || MAX >= (1 << W)) begin : g_chk
      $error("rtc_bcd_digit: MAX must be representable in W bits");
   end

   logic [W-1:0] q_q;
   logic         at_top;

   assign at_top = (q_q >= TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_q <= '0;
      else if (ld_i)  q_q <= ld_val_i;
      else if (inc_i) q_q <= at_top ? '0 : q_q + 1'b1;
   end

   assign q_o     = q_q;
   assign carry_o = inc_i & at_top;

   // R2
   digit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inc_i && !ld_i && (q_q < TOP) |=> q_q == $past(q_q) + 1'b1);

   // R9
   digit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inc_i && !ld_i && (q_q >= TOP) |=> q_q == '0);

   // R8
   digit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_i |=> q_q == $past(ld_val_i));

endmodule

// File: rtl/rtc_hold_ctrl.sv
module rtc_hold_ctrl #(
   parameter bit COMPENSATE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_rst_i,
   input  logic tick_i,
   input  logic busy_raw_i,
   input  logic ctrl_wr_i,
   input  logic ctrl_freeze_i,
   output logic hold_o,
   output logic busy_o,
   output logic missed_o,
   output logic release_o,
   output logic advance_o
);

   logic hold_q;
   logic hold_d;

   always_comb begin
      hold_d = hold_q;
      if (sw_rst_i)
         hold_d = 1'b0;
      else if (ctrl_wr_i)
         hold_d = hold_q ? ctrl_freeze_i : (ctrl_freeze_i & ~busy_raw_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= 1'b0;
      else        hold_q <= hold_d;
   end

   assign release_o = hold_q & ctrl_wr_i & ~ctrl_freeze_i & ~sw_rst_i;
   assign hold_o    = hold_q;
   assign busy_o    = busy_raw_i & ~hold_q;

   if (COMPENSATE) begin : g_comp
      logic missed_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                missed_q <= 1'b0;
         else if (sw_rst_i)         missed_q <= 1'b0;
         else if (release_o)        missed_q <= 1'b0;
         else if (hold_q && tick_i) missed_q <= 1'b1;
      end

      assign missed_o  = missed_q;
      assign advance_o = ~sw_rst_i &
                         ((~hold_q & tick_i) | (release_o & (missed_q | tick_i)));

      // R6
      missed_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
         hold_q && tick_i && !sw_rst_i && !release_o |=> missed_q && hold_q);
   end else begin : g_nocomp
      assign missed_o  = 1'b0;
      assign advance_o = ~sw_rst_i & ~hold_q & tick_i;
   end

   // R5
   refuse_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr_i && ctrl_freeze_i && busy_raw_i && !hold_q |=> !hold_q);

   // R10
   swrst_unfreeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst_i |=> !hold_q);

endmodule

// File: rtl/rtc_bcd_sec_min.sv
module rtc_bcd_sec_min #(
   parameter int DIV_W      = 15,
   parameter int BUSY_CYC   = 131,
   parameter int DATA_W     = 8,
   parameter int UNITS_W    = 4,
   parameter int TENS_W     = 3,
   parameter int UNITS_MAX  = 9,
   parameter int TENS_MAX   = 5,
   parameter bit COMPENSATE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sw_rst,
   input  logic                       wr_en,
   input  logic [rtc_pkg::ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [rtc_pkg::ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0]          rd_data
);

   import rtc_pkg::*;

   localparam int NPAIR   = 2;
   localparam int DIGIT_W = UNITS_W + TENS_W;
   localparam int PAD_W   = DATA_W - DIGIT_W;

   if (PAD_W != 1) begin : g_chk_layout
      $error("rtc_bcd_sec_min: DATA_W must equal UNITS_W + TENS_W + 1");
   end
   if (TENS_W >= UNITS_W) begin : g_chk_tens
      $error("rtc_bcd_sec_min: tens digit must be narrower than units digit");
   end

   logic tick;
   logic busy_raw;
   logic busy;
   logic hold;
   logic missed;
   logic rel;
   logic advance;
   logic ctrl_wr;
   logic ld_sec;
   logic ld_min;

   logic [UNITS_W-1:0] units_q [NPAIR];
   logic [TENS_W-1:0]  tens_q  [NPAIR];
   logic [2*NPAIR:0]   carry;

   logic [DATA_W-1:0] sec_word;
   logic [DATA_W-1:0] min_word;
   logic [DATA_W-1:0] ctrl_word;

   rtc_subsec_div #(
      .DIV_W    (DIV_W),
      .BUSY_CYC (BUSY_CYC)
   ) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_rst_i   (sw_rst),
      .tick_o     (tick),
      .busy_raw_o (busy_raw)
   );

   assign ctrl_wr = wr_en && (wr_addr == RA_CTRL);

   rtc_hold_ctrl #(
      .COMPENSATE (COMPENSATE)
   ) u_hold (
      .clk           (clk),
      .rst_n         (rst_n),
      .sw_rst_i      (sw_rst),
      .tick_i        (tick),
      .busy_raw_i    (busy_raw),
      .ctrl_wr_i     (ctrl_wr),
      .ctrl_freeze_i (wr_data[CTRL_FREEZE_BIT]),
      .hold_o        (hold),
      .busy_o        (busy),
      .missed_o      (missed),
      .release_o     (rel),
      .advance_o     (advance)
   );

   assign ld_sec = wr_en && (wr_addr == RA_SEC) && hold;
   assign ld_min = wr_en && (wr_addr == RA_MIN) && hold;

   assign carry[0] = advance;

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      logic ld;
      assign ld = (p == 0) ? ld_sec : ld_min;

      rtc_bcd_digit #(
         .W   (UNITS_W),
         .MAX (UNITS_MAX)
      ) u_units (
         .clk      (clk),
         .rst_n    (rst_n),
         .inc_i    (carry[2*p]),
         .ld_i     (ld),
         .ld_val_i (wr_data[UNITS_W-1:0]),
         .q_o      (units_q[p]),
         .carry_o  (carry[2*p+1])
      );

      rtc_bcd_digit #(
         .W   (TENS_W),
         .MAX (TENS_MAX)
      ) u_tens (
         .clk      (clk),
         .rst_n    (rst_n),
         .inc_i    (carry[2*p+1]),
         .ld_i     (ld),
         .ld_val_i (wr_data[UNITS_W +: TENS_W]),
         .q_o      (tens_q[p]),
         .carry_o  (carry[2*p+2])
      );
   end

   assign sec_word  = {{PAD_W{1'b0}}, tens_q[0], units_q[0]};
   assign min_word  = {{PAD_W{1'b0}}, tens_q[1], units_q[1]};

   always_comb begin
      ctrl_word                  = '0;
      ctrl_word[CTRL_FREEZE_BIT] = hold;
      ctrl_word[CTRL_BUSY_BIT]   = busy;
   end

   always_comb begin
      case (rd_addr)
         RA_CTRL: rd_data = ctrl_word;
         RA_SEC:  rd_data = sec_word;
         RA_MIN:  rd_data = min_word;
         default: rd_data = '0;
      endcase
   end

   logic [1:0] unused_bits;
   assign unused_bits = {wr_data[DATA_W-1], carry[2*NPAIR]};

   // R1
   pad_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[DATA_W-1]);

   // R6
   frozen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold && !wr_en && !sw_rst |=> $stable({min_word, sec_word}));

   // R6
   frozen_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> !rd_data[CTRL_BUSY_BIT] || (rd_addr != RA_CTRL));

   // R7
   release_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel && missed |=> {min_word, sec_word} != $past({min_word, sec_word}));

   // R7
   release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel && !missed && !tick |=> $stable({min_word, sec_word}));

   // R8
   write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (wr_addr != RA_CTRL) && !hold && !tick |=> $stable({min_word, sec_word}));

   // R10
   swrst_keeps_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst && !wr_en |=> $stable({min_word, sec_word}));

endmodule

// File: tb/rtc_bcd_sec_min_tb.sv
module rtc_bcd_sec_min_tb;

   localparam int CLK_PER  = 10;
   localparam int DIV_W    = 6;
   localparam int BUSY_CYC = 5;
   localparam int PERIOD   = 1 << DIV_W;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sw_rst = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   rtc_bcd_sec_min #(.DIV_W(DIV_W), .BUSY_CYC(BUSY_CYC)) u_dut (
      .clk, .rst_n, .sw_rst, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data
   );

   always #(CLK_PER/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000 && !done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got=%0d cycles exp=<100000", cyc);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got=%0h exp=%0h", req, got, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic wait_busy(input bit lvl);
      logic [7:0] v;
      bit hit = 1'b0;
      for (int i = 0; i < 4*PERIOD && !hit; i++) begin
         @(negedge clk);
         rd(2'd0, v);
         if (v[1] == lvl) hit = 1'b1;
      end
      if (!hit) chk("R4 busy wait timeout", 0, 1);
   endtask

   task automatic wait_rise();
      wait_busy(1'b0);
      wait_busy(1'b1);
   endtask

   // independent model of one-second advance: returns {min, sec}
   function automatic logic [15:0] add_sec(input logic [7:0] s, input logic [7:0] m);
      logic [3:0] su = s[3:0]; logic [2:0] st = s[6:4];
      logic [3:0] mu = m[3:0]; logic [2:0] mt = m[6:4];
      bit c;
      c = (su >= 9); su = c ? 4'd0 : su + 4'd1;
      if (c) begin c = (st >= 5); st = c ? 3'd0 : st + 3'd1; end
      if (c) begin c = (mu >= 9); mu = c ? 4'd0 : mu + 4'd1; end
      if (c) begin mt = (mt >= 5) ? 3'd0 : mt + 3'd1; end
      return {1'b0, mt, mu, 1'b0, st, su};
   endfunction

   task automatic set_time(input logic [7:0] s, input logic [7:0] m);
      wait_rise();
      wait_busy(1'b0);
      wr(2'd0, 8'h01);
      wr(2'd1, s);
      wr(2'd2, m);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      @(negedge clk);
      rd(2'd0, v); chk("R11 ctrl after reset", v, 8'h00);
      rd(2'd1, v); chk("R11 sec after reset", v, 8'h00);
      rd(2'd2, v); chk("R11 min after reset", v, 8'h00);
      rd(2'd3, v); chk("R1 unused address", v, 8'h00);
   endtask

   task automatic t_count_carry();
      logic [7:0] s, m;
      set_time(8'h58, 8'h07);
      @(negedge clk);
      rd(2'd1, s); chk("R8 write while frozen", s, 8'h58);
      wait_rise();
      rd(2'd1, s); chk("R2 units step", s, 8'h59);
      wait_rise();
      rd(2'd1, s); rd(2'd2, m);
      chk("R3 tens wrap sec", s, 8'h00);
      chk("R3 carry into minutes", m, 8'h08);
      set_time(8'h09, 8'h00);
      wait_rise();
      rd(2'd1, s); chk("R2 units wrap carry", s, 8'h10);
      set_time(8'h59, 8'h59);
      wait_rise();
      rd(2'd1, s); rd(2'd2, m);
      chk("R3 full roll sec", s, 8'h00);
      chk("R3 full roll min", m, 8'h00);
   endtask

   task automatic t_busy_window();
      logic [7:0] v;
      int c0, n;
      wait_rise();
      c0 = cyc; n = 1;
      for (int i = 0; i < PERIOD; i++) begin
         @(negedge clk);
         rd(2'd0, v);
         if (!v[1]) break;
         n++;
      end
      chk("R4 busy length", n, BUSY_CYC);
      wait_busy(1'b1);
      chk("R4 tick spacing", cyc - c0, PERIOD);
   endtask

   task automatic t_refuse();
      logic [7:0] v;
      wait_rise();
      wr(2'd0, 8'h01);
      @(negedge clk);
      rd(2'd0, v); chk("R5 freeze refused while busy", v[0], 0);
      wait_busy(1'b0);
      wr(2'd0, 8'h01);
      @(negedge clk);
      rd(2'd0, v); chk("R6 freeze accepted, busy 0", v, 8'h01);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_hold_missed();
      logic [7:0] s0, m0, s, m, v;
      logic [15:0] e;
      int c0, busy_seen;
      wait_rise();
      c0 = cyc;
      wait_busy(1'b0);
      rd(2'd1, s0); rd(2'd2, m0);
      wr(2'd0, 8'h01);
      busy_seen = 0;
      for (int i = 0; i < 140; i++) begin
         @(negedge clk);
         rd(2'd0, v);
         if (v[1]) busy_seen++;
      end
      chk("R6 busy reads 0 while frozen", busy_seen, 0);
      rd(2'd1, s); chk("R6 frozen seconds", s, s0);
      wr(2'd0, 8'h00);
      @(negedge clk);
      e = add_sec(s0, m0);
      rd(2'd1, s); rd(2'd2, m);
      chk("R7 one second added sec", s, e[7:0]);
      chk("R7 one second added min", m, e[15:8]);
      wait_rise();
      chk("R6 divider kept phase", (cyc - c0) % PERIOD, 0);
      e = add_sec(e[7:0], e[15:8]);
      rd(2'd1, s); chk("R7 no further catch-up", s, e[7:0]);
   endtask

   task automatic t_hold_nomiss();
      logic [7:0] s0, s;
      wait_rise();
      wait_busy(1'b0);
      rd(2'd1, s0);
      wr(2'd0, 8'h01);
      wr(2'd0, 8'h00);
      @(negedge clk);
      rd(2'd1, s); chk("R7 release without missed tick", s, s0);
   endtask

   task automatic t_ignored_write();
      logic [7:0] s0, m0, s, m;
      wait_rise();
      wait_busy(1'b0);
      rd(2'd1, s0); rd(2'd2, m0);
      wr(2'd1, 8'h33);
      wr(2'd2, 8'h44);
      @(negedge clk);
      rd(2'd1, s); rd(2'd2, m);
      chk("R8 sec write ignored unfrozen", s, s0);
      chk("R8 min write ignored unfrozen", m, m0);
   endtask

   task automatic t_invalid();
      logic [7:0] s, m;
      set_time(8'h3C, 8'h12);
      @(negedge clk);
      rd(2'd1, s); chk("R9 invalid units stored", s, 8'h3C);
      wait_rise();
      rd(2'd1, s); chk("R9 invalid units wrap", s, 8'h40);
      set_time(8'h79, 8'h12);
      wait_rise();
      rd(2'd1, s); rd(2'd2, m);
      chk("R9 invalid tens wrap", s, 8'h00);
      chk("R9 invalid tens carry", m, 8'h13);
      set_time(8'hFF, 8'h00);
      @(negedge clk);
      rd(2'd1, s); chk("R1 bit 7 reads 0", s, 8'h7F);
   endtask

   task automatic t_sw_reset();
      logic [7:0] s0, m0, s, v;
      logic [15:0] e;
      int ce;
      wait_rise();
      wait_busy(1'b0);
      wr(2'd0, 8'h01);
      @(negedge clk);
      rd(2'd1, s0); rd(2'd2, m0);
      sw_rst = 1'b1;
      @(posedge clk);
      #1;
      ce = cyc;
      sw_rst = 1'b0;
      @(negedge clk);
      rd(2'd0, v); chk("R10 freeze cleared", v, 8'h00);
      rd(2'd1, s); chk("R10 seconds kept", s, s0);
      wait_rise();
      chk("R10 divider restarted", cyc - ce, PERIOD);
      e = add_sec(s0, m0);
      rd(2'd1, s); chk("R10 normal count after", s, e[7:0]);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_count_carry();
      t_busy_window();
      t_refuse();
      t_hold_missed();
      t_hold_nomiss();
      t_ignored_write();
      t_invalid();
      t_sw_reset();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule